// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Selectable Write-Cycle Output

This block is a true dual-port synchronous RAM. Two ports, A and B, share one clock. Either port can read or write any location on any edge. Each port has an enable, a write strobe, an address and write data. Each port also has a read output that is registered on the same edge that samples the address.

A parameter per port chooses what that port's output shows while it writes. It can show the word being stored, the word being replaced, or the unchanged previous output. The two ports can use different choices.

Same-address access from both ports in one cycle is watched by a collision monitor. Combinations that give unreliable results raise a one-cycle collision output. When a read is unreliable, the monitor also raises a per-port flag that marks that port's read data as invalid. In a four-state simulator that data is driven to unknown. Both ports reading one word together is always legal. Both ports writing identical data to one word is also legal. A read that meets a write on the other port is legal only when the writing port returns the replaced word.

Top module: `dpram_rdw`

## Requirements
- R1: While `rst` is high on a clock edge, both read outputs, `clash` and both invalid flags become zero on that edge. Memory contents are not cleared.
- R2: A read (`x_en`=1, `x_we`=0) presents the addressed word on that port's read output after the same clock edge that sampled the address: one cycle of latency.
- R3: A port whose mode is write-first shows its own write data on its read output after a write edge. This holds even when the other port writes the same word.
- R4: A port whose mode is read-first shows the word held at the address before the write, after a write edge.
- R5: A port whose mode is no-change keeps its read output unchanged across a write edge.
- R6: A disabled port (`x_en`=0) keeps its read output unchanged and stores nothing, whatever its write strobe, address and data are.
- R7: Both ports reading the same address in one cycle give equal read outputs and no collision.
- R8: Both ports writing identical data to the same address store that data with no collision.
- R9: Both ports writing different data to the same address raise `clash` after that edge. The stored word is then unreliable.
- R10: When one port writes and the other reads the same address, and the writer is in read-first mode, the reader gets the old word and `clash` stays low.
- R11: When one port writes and the other reads the same address, and the writer is in write-first or no-change mode, `clash` and the reader's invalid flag are high for exactly the cycle after that edge. The reader's data is unknown.
- R12: Accesses to different addresses never interact and never raise `clash`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset of outputs and flags |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write strobe |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write strobe |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| a_rdata | output | DATA_W | Port A registered read output |
| b_rdata | output | DATA_W | Port B registered read output |
| clash | output | 1 | One-cycle same-address collision indicator |
| a_bad | output | 1 | Port A read data from the last edge is invalid |
| b_bad | output | 1 | Port B read data from the last edge is invalid |

## Verification
The bench targets the same-address cases. A read that meets a read-first writer must return the old word with no flag. A design that lets the write through first would return new data there. A read that meets a write-first or no-change writer must raise the collision flag and the reader's invalid flag. A monitor that only checked write/write pairs would stay silent on that case.

Identical-data double writes must stay quiet, while differing data must flag. A disabled port given a write strobe is later read back to show that nothing was stored. Two instances with different mode pairs receive the same stimulus, so the same pattern gives different verdicts depending on the writer's mode.

// File: rtl/dpram_rdw_pkg.sv
package dpram_rdw_pkg;

    // Output behaviour of a port on its own write cycle
    typedef enum logic [1:0] {
        RDW_WRITE_FIRST = 2'd0,
        RDW_READ_FIRST  = 2'd1,
        RDW_NO_CHANGE   = 2'd2
    } rdw_mode_e;

    // A writer in this mode corrupts a same-cycle read on the other port
    function automatic logic spoils_peer_read(rdw_mode_e m);
        return (m != RDW_READ_FIRST);
    endfunction

endpackage

// File: rtl/dpram_clash.sv
module dpram_clash
    import dpram_rdw_pkg::*;
#(
    parameter int        ADDR_W = 4,
    parameter int        DATA_W = 8,
    parameter rdw_mode_e MODE_A = RDW_WRITE_FIRST,
    parameter rdw_mode_e MODE_B = RDW_READ_FIRST
) (
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic              dual_wr,   // both ports write one word
    output logic              wr_fight,  // ... with differing data
    output logic              a_spoil,   // port A read is unreliable
    output logic              b_spoil    // port B read is unreliable
);
    logic same_word;

    always_comb begin
        same_word = a_en && b_en && (a_addr == b_addr);
        dual_wr   = same_word && a_we && b_we;
        wr_fight  = dual_wr && (a_wdata != b_wdata);
        a_spoil   = same_word && !a_we && b_we && spoils_peer_read(MODE_B);
        b_spoil   = same_word && !b_we && a_we && spoils_peer_read(MODE_A);
    end

endmodule

// File: rtl/dpram_out_sel.sv
module dpram_out_sel
    import dpram_rdw_pkg::*;
#(
    parameter int        DATA_W = 8,
    parameter rdw_mode_e MODE   = RDW_WRITE_FIRST
) (
    input  logic              en,
    input  logic              we,
    input  logic              spoil,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] stored,   // word before this edge
    input  logic [DATA_W-1:0] cur,      // present read output
    output logic [DATA_W-1:0] nxt
);
    always_comb begin
        nxt = cur;
        if (en) begin
            if (!we) begin
                nxt = spoil ? {DATA_W{1'bx}} : stored;
            end else begin
                case (MODE)
                    RDW_WRITE_FIRST: nxt = wdata;
                    RDW_READ_FIRST:  nxt = stored;
                    default:         nxt = cur;
                endcase
            end
        end
    end

endmodule

// File: rtl/dpram_rdw.sv
module dpram_rdw
    import dpram_rdw_pkg::*;
#(
    parameter int        ADDR_W = 4,
    parameter int        DATA_W = 8,
    parameter rdw_mode_e MODE_A = RDW_WRITE_FIRST,
    parameter rdw_mode_e MODE_B = RDW_READ_FIRST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              clash,
    output logic              a_bad,
    output logic              b_bad
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NPORTS = 2;

    logic [DATA_W-1:0] mem [DEPTH];

    logic dual_wr, wr_fight, a_spoil, b_spoil;

    dpram_clash #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_A(MODE_A), .MODE_B(MODE_B)
    ) u_clash (
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .dual_wr(dual_wr), .wr_fight(wr_fight),
        .a_spoil(a_spoil), .b_spoil(b_spoil)
    );

    // Per-port views for the generated output selectors
    logic              p_en    [NPORTS];
    logic              p_we    [NPORTS];
    logic              p_spoil [NPORTS];
    logic [DATA_W-1:0] p_wdata [NPORTS];
    logic [DATA_W-1:0] p_stored[NPORTS];
    logic [DATA_W-1:0] p_cur   [NPORTS];
    logic [DATA_W-1:0] p_nxt   [NPORTS];

    always_comb begin
        p_en[0]     = a_en;      p_en[1]     = b_en;
        p_we[0]     = a_we;      p_we[1]     = b_we;
        p_spoil[0]  = a_spoil;   p_spoil[1]  = b_spoil;
        p_wdata[0]  = a_wdata;   p_wdata[1]  = b_wdata;
        p_stored[0] = mem[a_addr];
        p_stored[1] = mem[b_addr];
        p_cur[0]    = a_rdata;   p_cur[1]    = b_rdata;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam rdw_mode_e PMODE = (p == 0) ? MODE_A : MODE_B;
        dpram_out_sel #(
            .DATA_W(DATA_W), .MODE(PMODE)
        ) u_sel (
            .en(p_en[p]), .we(p_we[p]), .spoil(p_spoil[p]),
            .wdata(p_wdata[p]), .stored(p_stored[p]),
            .cur(p_cur[p]), .nxt(p_nxt[p])
        );
    end

    // Storage: a same-word double write is merged into one store
    always_ff @(posedge clk) begin
        if (a_en && a_we) begin
            mem[a_addr] <= wr_fight ? {DATA_W{1'bx}} : a_wdata;
        end
        if (b_en && b_we && !dual_wr) begin
            mem[b_addr] <= b_wdata;
        end
    end

    // Registered outputs and collision flags
    always_ff @(posedge clk) begin
        if (rst) begin
            a_rdata <= '0;
            b_rdata <= '0;
            clash   <= 1'b0;
            a_bad   <= 1'b0;
            b_bad   <= 1'b0;
        end else begin
            a_rdata <= p_nxt[0];
            b_rdata <= p_nxt[1];
            clash   <= wr_fight || a_spoil || b_spoil;
            a_bad   <= a_spoil;
            b_bad   <= b_spoil;
        end
    end

endmodule

// File: rtl/dpram_rdw_chk.sv
module dpram_rdw_chk
    import dpram_rdw_pkg::*;
#(
    parameter int        ADDR_W = 4,
    parameter int        DATA_W = 8,
    parameter rdw_mode_e MODE_A = RDW_WRITE_FIRST,
    parameter rdw_mode_e MODE_B = RDW_READ_FIRST
) (
    input logic              clk,
    input logic              rst,
    input logic              a_en,
    input logic              a_we,
    input logic [ADDR_W-1:0] a_addr,
    input logic [DATA_W-1:0] a_wdata,
    input logic              b_en,
    input logic              b_we,
    input logic [ADDR_W-1:0] b_addr,
    input logic [DATA_W-1:0] b_wdata,
    input logic [DATA_W-1:0] a_rdata,
    input logic [DATA_W-1:0] b_rdata,
    input logic              clash,
    input logic              a_bad,
    input logic              b_bad
);
    // R1: reset clears flags on the next edge
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!clash && !a_bad && !b_bad));

    // R3: write-first port echoes its write data
    assert_a_wf_echo_R3: assert property (@(posedge clk) disable iff (rst)
        (MODE_A == RDW_WRITE_FIRST && a_en && a_we) |=> (a_rdata == $past(a_wdata)));
    assert_b_wf_echo_R3: assert property (@(posedge clk) disable iff (rst)
        (MODE_B == RDW_WRITE_FIRST && b_en && b_we) |=> (b_rdata == $past(b_wdata)));

    // R5: no-change port holds its output during a write
    assert_a_nc_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (MODE_A == RDW_NO_CHANGE && a_en && a_we) |=> $stable(a_rdata));
    assert_b_nc_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (MODE_B == RDW_NO_CHANGE && b_en && b_we) |=> $stable(b_rdata));

    // R6: disabled port holds its output
    assert_a_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !a_en |=> $stable(a_rdata));
    assert_b_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !b_en |=> $stable(b_rdata));

    // R7: shared read agrees and is quiet
    assert_shared_read_R7: assert property (@(posedge clk) disable iff (rst)
        (a_en && b_en && !a_we && !b_we && a_addr == b_addr)
        |=> (a_rdata == b_rdata && !clash));

    // R9: differing double write is reported
    assert_write_fight_R9: assert property (@(posedge clk) disable iff (rst)
        (a_en && b_en && a_we && b_we && a_addr == b_addr && a_wdata != b_wdata)
        |=> clash);

    // R11: an invalid flag never appears without the collision output
    assert_bad_has_clash_R11: assert property (@(posedge clk) disable iff (rst)
        (a_bad || b_bad) |-> clash);

    // R12: different addresses never collide
    assert_apart_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (a_addr != b_addr) |=> !clash);

endmodule

bind dpram_rdw dpram_rdw_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_A(MODE_A), .MODE_B(MODE_B)
) u_chk (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .a_rdata(a_rdata), .b_rdata(b_rdata),
    .clash(clash), .a_bad(a_bad), .b_bad(b_bad)
);

// File: tb/sim_dpram_rdw.sv
module sim_dpram_rdw;
    import dpram_rdw_pkg::*;

    localparam int AW = 4;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;   // 100 MHz

    logic          a_en = 1'b0, a_we = 1'b0, b_en = 1'b0, b_we = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;

    logic [DW-1:0] a0, b0, a1, b1;
    logic          c0, c1, ab0, bb0, ab1, bb1;

    // u0: A write-first, B read-first
    dpram_rdw #(.ADDR_W(AW), .DATA_W(DW),
                .MODE_A(RDW_WRITE_FIRST), .MODE_B(RDW_READ_FIRST)) u0 (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .a_rdata(a0), .b_rdata(b0), .clash(c0), .a_bad(ab0), .b_bad(bb0));

    // u1: A no-change, B write-first, same stimulus
    dpram_rdw #(.ADDR_W(AW), .DATA_W(DW),
                .MODE_A(RDW_NO_CHANGE), .MODE_B(RDW_WRITE_FIRST)) u1 (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .a_rdata(a1), .b_rdata(b1), .clash(c1), .a_bad(ab1), .b_bad(bb1));

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns after the next rising edge
    task automatic drive(input logic ea, input logic wa, input logic [AW-1:0] aa,
                         input logic [DW-1:0] da, input logic eb, input logic wb,
                         input logic [AW-1:0] ab, input logic [DW-1:0] db);
        @(negedge clk);
        a_en = ea; a_we = wa; a_addr = aa; a_wdata = da;
        b_en = eb; b_we = wb; b_addr = ab; b_wdata = db;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        a_en = 1'b0; b_en = 1'b0; a_we = 1'b0; b_we = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 u0 a_rdata", 32'(a0), 32'h0);
        chk("R1 u0 b_rdata", 32'(b0), 32'h0);
        chk("R1 u1 a_rdata", 32'(a1), 32'h0);
        chk("R1 u1 b_rdata", 32'(b1), 32'h0);
        chk("R1 flags",      32'({c0, ab0, bb0, c1, ab1, bb1}), 32'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Vector: ea wa aa da | eb wb ab db | exp_a exp_b chk_b exp_clash  (u0)
    localparam int NV = 13;
    localparam logic [45:0] VEC [NV] = '{
        {1'b1,1'b1,4'd3,8'h11, 1'b0,1'b0,4'd0,8'h00, 8'h11,8'h00,1'b1,1'b0}, // R3
        {1'b1,1'b1,4'd5,8'h22, 1'b0,1'b0,4'd0,8'h00, 8'h22,8'h00,1'b1,1'b0}, // R3
        {1'b0,1'b1,4'd3,8'hEE, 1'b1,1'b1,4'd3,8'h33, 8'h22,8'h11,1'b1,1'b0}, // R4 R6
        {1'b1,1'b0,4'd3,8'h00, 1'b1,1'b0,4'd5,8'h00, 8'h33,8'h22,1'b1,1'b0}, // R2 R6 R12
        {1'b1,1'b0,4'd5,8'h00, 1'b1,1'b0,4'd5,8'h00, 8'h22,8'h22,1'b1,1'b0}, // R7
        {1'b1,1'b1,4'd7,8'h40, 1'b0,1'b0,4'd0,8'h00, 8'h40,8'h22,1'b1,1'b0}, // R3
        {1'b1,1'b1,4'd7,8'h44, 1'b1,1'b1,4'd7,8'h44, 8'h44,8'h40,1'b1,1'b0}, // R8
        {1'b1,1'b0,4'd7,8'h00, 1'b0,1'b0,4'd0,8'h00, 8'h44,8'h40,1'b1,1'b0}, // R8
        {1'b1,1'b0,4'd5,8'h00, 1'b1,1'b1,4'd5,8'h55, 8'h22,8'h22,1'b1,1'b0}, // R10
        {1'b1,1'b0,4'd5,8'h00, 1'b1,1'b0,4'd3,8'h00, 8'h55,8'h33,1'b1,1'b0}, // R2 R12
        {1'b1,1'b1,4'd3,8'h66, 1'b1,1'b0,4'd3,8'h00, 8'h66,8'h00,1'b0,1'b1}, // R11
        {1'b1,1'b1,4'd9,8'h01, 1'b1,1'b1,4'd9,8'h02, 8'h01,8'h00,1'b0,1'b1}, // R9
        {1'b0,1'b0,4'd0,8'h00, 1'b0,1'b0,4'd0,8'h00, 8'h01,8'h00,1'b0,1'b0}  // R11 one cycle
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        do_reset();   // R1

        for (int i = 0; i < NV; i++) begin
            logic [45:0] v;
            v = VEC[i];
            drive(v[45], v[44], v[43:40], v[39:32], v[31], v[30], v[29:26], v[25:18]);
            chk($sformatf("table step %0d u0 a_rdata", i), 32'(a0), 32'(v[17:10]));
            if (v[1]) chk($sformatf("table step %0d u0 b_rdata", i), 32'(b0), 32'(v[9:2]));
            chk($sformatf("table step %0d u0 clash", i), 32'(c0), 32'(v[0]));
            if (i == 10) chk("R11 u0 b_bad on write-first writer", 32'(bb0), 32'h1);
        end

        do_reset();   // R1 mid-run; memory keeps 3=66

        // R5: no-change writer keeps output, write-first echoes
        drive(1'b1, 1'b1, 4'd3, 8'h77, 1'b0, 1'b0, 4'd0, 8'h00);
        chk("R5 u1 a no-change hold", 32'(a1), 32'h0);
        chk("R3 u0 a write-first echo", 32'(a0), 32'h77);

        // R2: read back
        drive(1'b1, 1'b0, 4'd3, 8'h00, 1'b0, 1'b0, 4'd0, 8'h00);
        chk("R2 u1 a read latency", 32'(a1), 32'h77);

        // B writes 3, A reads 3: u1 writer write-first, u0 writer read-first
        drive(1'b1, 1'b0, 4'd3, 8'h00, 1'b1, 1'b1, 4'd3, 8'h88);
        chk("R11 u1 clash",    32'(c1),  32'h1);
        chk("R11 u1 a_bad",    32'(ab1), 32'h1);
        chk("R3 u1 b echo",    32'(b1),  32'h88);
        chk("R10 u0 no clash", 32'(c0),  32'h0);
        chk("R10 u0 a old",    32'(a0),  32'h77);
        chk("R4 u0 b old",     32'(b0),  32'h77);

        // A writes 3, B reads 3: u1 writer no-change, u0 writer write-first
        drive(1'b1, 1'b1, 4'd3, 8'h99, 1'b1, 1'b0, 4'd3, 8'h00);
        chk("R11 u1 clash nc writer", 32'(c1),  32'h1);
        chk("R11 u1 b_bad",           32'(bb1), 32'h1);
        chk("R11 u0 clash wf writer", 32'(c0),  32'h1);
        chk("R3 u0 a echo",           32'(a0),  32'h99);

        // Flags last one cycle
        drive(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 4'd0, 8'h00);
        chk("R11 flags drop", 32'({c0, ab0, bb0, c1, ab1, bb1}), 32'h0);

        // R7: shared read
        drive(1'b1, 1'b0, 4'd3, 8'h00, 1'b1, 1'b0, 4'd3, 8'h00);
        chk("R7 u0 a", 32'(a0), 32'h99);
        chk("R7 u0 b", 32'(b0), 32'h99);
        chk("R7 u1 clash", 32'(c1), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule